// File: doc/BRIEF.md
# Multidrop Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial transceiver with a small register-style host port. A host writes the mode, the interrupt mask, the baud divisor and the characters to send. It reads back received characters and a status word. Characters carry 6, 7 or 8 data bits. The slot after the data can hold a parity bit (even, odd, forced 0 or forced 1) or no bit at all. In multidrop mode that slot holds an address marker instead, so that one master can address many stations on a shared line.

The receiver oversamples the line at 16 times the bit rate. It checks a start bit at its middle and takes every later bit at its middle sample. It reports parity errors, missing stop bits, overruns and incoming line breaks. All error flags stay set until the host clears them. The transmitter can hold the line low to send a break. A channel-mode field sets how the pins are wired. In normal mode the pins are used as they are. In echo mode the incoming line is copied to the output while the receiver still works. In local loopback the transmitter feeds the receiver and the output pin idles high. In remote loopback the input pin drives the output pin and the receiver is cut off. Two plain strobes, one for a free holding register and one for a waiting received character, let an external DMA engine follow the data flow.

Top module: `mdrop_uart`

Register map (bus_addr): 0 control, write only: bit0 clears the error flags, bit1 starts a break, bit2 ends a break. 1 mode: [1:0] length (0=6, 1=7, 2=8 bits), [4:2] parity (0 even, 1 odd, 2 forced 0, 3 forced 1, 4..7 none), [5] multidrop, [7:6] channel (0 normal, 1 echo, 2 local loopback, 3 remote loopback). 2 interrupt mask, using the status bit positions. 3 divisor. 4 transmit data, with bit 8 as the address marker. 5 receive data, with bit 8 as the received marker; reading it clears the ready flag. 6 status: bit0 character ready, bit1 holding register free, bit2 transmitter idle, bit3 break seen, bit4 overrun, bit5 framing error, bit6 parity error.

## Requirements
- R1: After reset, txd is 1, irq is 0 and status reads 0x0006.
- R2: A frame on txd is a 0 start bit, then the data bits LSB first (6, 7 or 8 bits as the length field selects), then the extra bit when one is selected, then a 1 stop bit.
- R3: With parity selected, the extra bit makes the count of ones even (code 0) or odd (code 1), or is 0 (code 2) or 1 (code 3). Codes 4 to 7 send no extra bit.
- R4: In multidrop mode the extra bit is bit 8 of the transmit data, whatever the parity field says. On receive it is returned in bit 8 of the receive data.
- R5: A received character appears in the receive data with the unused upper data bits at 0 and sets status bit0. Reading register 5 clears status bit0.
- R6: A received parity bit that does not match the selected rule sets status bit6. Multidrop mode and the no-parity codes never set it.
- R7: A 0 stop bit on a character with some nonzero data bits sets status bit5.
- R8: A character that completes while status bit0 is still set sets status bit4, and the new character replaces the old one.
- R9: While a break is active txd is 0. Ending the break returns txd to 1.
- R10: A frame whose data and stop bits all read 0 sets status bit3 and delivers no character. It is reported only once until the line has gone high again.
- R11: In echo mode txd follows rxd and characters are still received. In local loopback txd stays 1 and transmitted characters are received. In remote loopback txd follows rxd and nothing is received.
- R12: irq is 1 exactly when some status bit and its mask bit are both 1.
- R13: The bit time is 16 times the divisor in clock cycles. A divisor of 0 stops all transmission until a nonzero value is written.
- R14: Writing control bit0 clears status bits 3 to 6 and leaves status bit0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (acts on register 5) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from bus_addr |
| rxd | input | 1 | Serial input line |
| txd | output | 1 | Serial output line |
| irq | output | 1 | Masked OR of the status flags |
| dma_tx_ready | output | 1 | Transmit holding register is free |
| dma_rx_valid | output | 1 | A received character is waiting |

## Verification
The hardest state to reach is the break rule: the line has to be held low for more than one frame time, the flag has to be cleared while the line is still low, and the bench then has to show that no second report arrives until the line has gone high and low again. The bench drives rxd itself with a bit-accurate frame builder. It holds the line low for fourteen bit times, clears the flags in the middle of the hold, and only then releases the line and breaks again. Random lengths, parity codes, multidrop settings and data values are sent out on txd and decoded at mid-bit, and then sent back through local loopback. Directed frames with a flipped parity bit, a zero stop bit or two characters in a row cover the error paths.

// File: rtl/mdu_pkg.sv
package mdu_pkg;
  localparam int FRAME_MAX = 11;

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_MODE = 3'd1;
  localparam logic [2:0] A_IEN  = 3'd2;
  localparam logic [2:0] A_DIV  = 3'd3;
  localparam logic [2:0] A_TXD  = 3'd4;
  localparam logic [2:0] A_RXD  = 3'd5;
  localparam logic [2:0] A_STAT = 3'd6;

  typedef enum logic [1:0] {
    CH_NORMAL = 2'd0,
    CH_ECHO   = 2'd1,
    CH_LOCAL  = 2'd2,
    CH_REMOTE = 2'd3
  } chan_e;

  // number of data bits for a length code
  function automatic logic [3:0] n_data(input logic [1:0] len);
    case (len)
      2'd0:    return 4'd6;
      2'd1:    return 4'd7;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic uses_extra(input logic [2:0] par, input logic md);
    return md | (par < 3'd4);
  endfunction

  function automatic logic [7:0] keep_bits(input logic [7:0] d, input logic [1:0] len);
    case (len)
      2'd0:    return d & 8'h3F;
      2'd1:    return d & 8'h7F;
      default: return d;
    endcase
  endfunction

  function automatic logic par_bit(input logic [7:0] d, input logic [1:0] len,
                                   input logic [2:0] par);
    logic [7:0] k;
    k = keep_bits(d, len);
    case (par)
      3'd0:    return ^k;
      3'd1:    return ~(^k);
      3'd2:    return 1'b0;
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [3:0] frame_len(input logic [1:0] len, input logic [2:0] par,
                                           input logic md);
    return 4'd2 + n_data(len) + {3'b000, uses_extra(par, md)};
  endfunction

  // start bit at index 0, stop bits fill everything above the last used slot
  function automatic logic [FRAME_MAX-1:0] build_frame(input logic [8:0] d, input logic [1:0] len,
                                                       input logic [2:0] par, input logic md);
    logic [FRAME_MAX-1:0] f;
    logic [3:0] n;
    n = n_data(len);
    f = '1;
    f[0] = 1'b0;
    for (int i = 0; i < 8; i++) begin
      if (4'(i) < n) f[i+1] = d[i];
    end
    if (uses_extra(par, md)) f[n + 4'd1] = md ? d[8] : par_bit(d[7:0], len, par);
    return f;
  endfunction
endpackage

// File: rtl/mdu_baud.sv
module mdu_baud #(
  parameter int CD_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [CD_W-1:0] cd,
  output logic            tick16
);
  logic [CD_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick16 <= 1'b0;
    end else if (cd == '0) begin
      cnt_q  <= '0;
      tick16 <= 1'b0;
    end else if (cnt_q >= cd - 1'b1) begin
      cnt_q  <= '0;
      tick16 <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      tick16 <= 1'b0;
    end
  end

  assert_div_zero_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (cd == '0) |=> !tick16);
endmodule

// File: rtl/mdu_tx.sv
module mdu_tx import mdu_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       load,
  input  logic [8:0] load_data,
  input  logic [1:0] len,
  input  logic [2:0] par,
  input  logic       md,
  input  logic       brk_set,
  input  logic       brk_clr,
  output logic       tx_out,
  output logic       hold_empty,
  output logic       idle
);
  logic [8:0]           hold_q;
  logic                 full_q, busy_q, brk_q;
  logic [FRAME_MAX-1:0] sh_q;
  logic [3:0]           left_q, sub_q;

  // a character starts only on a baud tick, so a zero divisor never starts one
  wire start_w = full_q && !busy_q && !brk_q && tick16;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      full_q <= 1'b0;
      busy_q <= 1'b0;
      brk_q  <= 1'b0;
      sh_q   <= '1;
      left_q <= '0;
      sub_q  <= '0;
    end else begin
      if (brk_set)      brk_q <= 1'b1;
      else if (brk_clr) brk_q <= 1'b0;

      if (load) begin
        hold_q <= load_data;
        full_q <= 1'b1;
      end else if (start_w) begin
        full_q <= 1'b0;
      end

      if (start_w) begin
        sh_q   <= build_frame(hold_q, len, par, md);
        left_q <= frame_len(len, par, md);
        sub_q  <= '0;
        busy_q <= 1'b1;
      end else if (busy_q && tick16) begin
        sub_q <= sub_q + 1'b1;
        if (sub_q == 4'd15) begin
          sh_q   <= {1'b1, sh_q[FRAME_MAX-1:1]};
          left_q <= left_q - 1'b1;
          if (left_q == 4'd1) busy_q <= 1'b0;
        end
      end
    end
  end

  assign tx_out     = brk_q ? 1'b0 : (busy_q ? sh_q[0] : 1'b1);
  assign hold_empty = !full_q;
  assign idle       = !full_q && !busy_q;

  assert_shift_on_tick_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !tick16) |=> $stable(sh_q));
  assert_ends_on_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(sh_q[0]));
endmodule

// File: rtl/mdu_rx.sv
module mdu_rx import mdu_pkg::*; (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick16,
  input  logic       rx_in,
  input  logic [1:0] len,
  input  logic [2:0] par,
  input  logic       md,
  input  logic       rd_ack,
  input  logic       clr_err,
  output logic [8:0] rx_data,
  output logic       rdy,
  output logic       ovr,
  output logic       ferr,
  output logic       perr,
  output logic       brk
);
  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS, RX_WAIT} rx_st_e;

  rx_st_e     st_q;
  logic [3:0] sub_q, idx_q;
  logic [9:0] vec_q, vec_w;
  logic [3:0] n_w, last_w;
  logic [7:0] dbits_w;
  logic       ex_w, ext_w, stp_w;

  assign n_w    = n_data(len);
  assign ex_w   = uses_extra(par, md);
  assign last_w = n_w + {3'b000, ex_w};

  always_comb begin
    vec_w = vec_q;
    vec_w[idx_q] = rx_in;
  end

  assign dbits_w = keep_bits(vec_w[7:0], len);
  assign ext_w   = vec_w[n_w];
  assign stp_w   = vec_w[last_w];

  wire sample_w = (st_q == RX_BITS) && tick16 && (sub_q == 4'd15);
  wire done_w   = sample_w && (idx_q == last_w);
  wire brk_w    = done_w && (dbits_w == 8'd0) && !stp_w;
  wire char_w   = done_w && !brk_w;
  wire bad_par  = !md && (par < 3'd4) && (ext_w != par_bit(dbits_w, len, par));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= RX_IDLE;
      sub_q   <= '0;
      idx_q   <= '0;
      vec_q   <= '0;
      rx_data <= '0;
      rdy     <= 1'b0;
      ovr     <= 1'b0;
      ferr    <= 1'b0;
      perr    <= 1'b0;
      brk     <= 1'b0;
    end else begin
      case (st_q)
        RX_IDLE: if (tick16 && !rx_in) begin
          st_q  <= RX_START;
          sub_q <= '0;
        end
        RX_START: if (tick16) begin
          if (sub_q == 4'd7) begin
            sub_q <= '0;
            idx_q <= '0;
            vec_q <= '0;
            st_q  <= rx_in ? RX_IDLE : RX_BITS;
          end else begin
            sub_q <= sub_q + 1'b1;
          end
        end
        RX_BITS: if (tick16) begin
          sub_q <= sub_q + 1'b1;
          if (sub_q == 4'd15) begin
            vec_q <= vec_w;
            idx_q <= idx_q + 1'b1;
            if (done_w) st_q <= brk_w ? RX_WAIT : RX_IDLE;
          end
        end
        default: if (rx_in) st_q <= RX_IDLE;
      endcase

      if (clr_err) begin
        ovr  <= 1'b0;
        ferr <= 1'b0;
        perr <= 1'b0;
        brk  <= 1'b0;
      end
      if (rd_ack) rdy <= 1'b0;
      if (char_w) begin
        rx_data <= {md & ext_w, dbits_w};
        rdy     <= 1'b1;
        if (rdy && !rd_ack) ovr  <= 1'b1;
        if (!stp_w)         ferr <= 1'b1;
        if (bad_par)        perr <= 1'b1;
      end
      if (brk_w) brk <= 1'b1;
    end
  end

  assert_overrun_sets_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (char_w && rdy && !rd_ack) |=> ovr);
  assert_break_waits_high_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_WAIT && !rx_in) |=> (st_q == RX_WAIT));
endmodule

// File: rtl/mdrop_uart.sv
module mdrop_uart import mdu_pkg::*; #(
  parameter int CD_W = 16,
  parameter int DW   = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [2:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          rxd,
  output logic          txd,
  output logic          irq,
  output logic          dma_tx_ready,
  output logic          dma_rx_valid
);
  localparam int ST_W = 8;

  logic [7:0]      mode_q;
  logic [ST_W-1:0] ien_q;
  logic [CD_W-1:0] cd_q;
  logic            sy1_q, sy2_q;
  logic            tick16, tx_line, hold_empty, tx_idle;
  logic [8:0]      rx_data;
  logic            rdy, ovr, ferr, perr, brk;
  logic [ST_W-1:0] status_w;

  wire [1:0] len_w = mode_q[1:0];
  wire [2:0] par_w = mode_q[4:2];
  wire       md_w  = mode_q[5];
  chan_e     ch_w;
  assign ch_w = chan_e'(mode_q[7:6]);

  wire wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  wire clr_w   = wr_ctrl && bus_wdata[0];
  wire bon_w   = wr_ctrl && bus_wdata[1];
  wire boff_w  = wr_ctrl && bus_wdata[2];
  wire load_w  = bus_wr && (bus_addr == A_TXD);
  wire rd_w    = bus_rd && (bus_addr == A_RXD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      ien_q  <= '0;
      cd_q   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MODE:  mode_q <= bus_wdata[7:0];
        A_IEN:   ien_q  <= bus_wdata[ST_W-1:0];
        A_DIV:   cd_q   <= bus_wdata[CD_W-1:0];
        default: ;
      endcase
    end
  end

  // receiver source per channel mode, then a two-stage synchronizer
  wire rx_src = (ch_w == CH_LOCAL)  ? tx_line :
                (ch_w == CH_REMOTE) ? 1'b1    : rxd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sy1_q <= 1'b1;
      sy2_q <= 1'b1;
    end else begin
      sy1_q <= rx_src;
      sy2_q <= sy1_q;
    end
  end

  mdu_baud #(.CD_W(CD_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .cd(cd_q), .tick16(tick16)
  );

  mdu_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .load(load_w),
    .load_data(bus_wdata[8:0]), .len(len_w), .par(par_w), .md(md_w),
    .brk_set(bon_w), .brk_clr(boff_w), .tx_out(tx_line),
    .hold_empty(hold_empty), .idle(tx_idle)
  );

  mdu_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_in(sy2_q),
    .len(len_w), .par(par_w), .md(md_w), .rd_ack(rd_w), .clr_err(clr_w),
    .rx_data(rx_data), .rdy(rdy), .ovr(ovr), .ferr(ferr), .perr(perr), .brk(brk)
  );

  assign status_w = {1'b0, perr, ferr, ovr, brk, tx_idle, hold_empty, rdy};

  always_comb begin
    case (bus_addr)
      A_MODE:  bus_rdata = DW'(mode_q);
      A_IEN:   bus_rdata = DW'(ien_q);
      A_DIV:   bus_rdata = DW'(cd_q);
      A_RXD:   bus_rdata = DW'(rx_data);
      A_STAT:  bus_rdata = DW'(status_w);
      default: bus_rdata = '0;
    endcase
  end

  assign txd = ((ch_w == CH_ECHO) || (ch_w == CH_REMOTE)) ? rxd :
               (ch_w == CH_LOCAL) ? 1'b1 : tx_line;
  assign irq          = |(status_w & ien_q);
  assign dma_tx_ready = hold_empty;
  assign dma_rx_valid = rdy;

  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |-> !irq);
endmodule

// File: tb/mdrop_uart_bench.sv
module mdrop_uart_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CDV  = 2;
  localparam int BITP = 16 * CDV;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        rxd = 1'b1;
  logic        txd, irq, dma_tx_ready, dma_rx_valid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdrop_uart u_mdrop_uart (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rxd(rxd), .txd(txd), .irq(irq),
    .dma_tx_ready(dma_tx_ready), .dma_rx_valid(dma_rx_valid)
  );

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
      summary();
    end
  end

  // bench model of a serial frame: bit 0 is the start bit
  function automatic logic [10:0] bframe(input logic [8:0] d, input int lc, input int pm,
                                         input bit md, input bit stp, output int cnt);
    logic [10:0] f;
    int nb, pos, ones;
    nb = 6 + lc;
    f = '1;
    f[0] = 1'b0;
    ones = 0;
    for (int i = 0; i < nb; i++) begin
      f[1+i] = d[i];
      ones += d[i];
    end
    pos = 1 + nb;
    if (md) begin
      f[pos] = d[8];
      pos++;
    end else if (pm < 4) begin
      case (pm)
        0: f[pos] = ones % 2;
        1: f[pos] = !(ones % 2);
        2: f[pos] = 1'b0;
        default: f[pos] = 1'b1;
      endcase
      pos++;
    end
    f[pos] = stp;
    cnt = pos + 1;
    return f;
  endfunction

  function automatic logic [15:0] mval(input int lc, input int pm, input bit md, input int ch);
    return {8'h00, 2'(ch), md, 3'(pm), 2'(lc)};
  endfunction

  function automatic logic [15:0] rx_expect(input logic [8:0] d, input int lc, input bit md);
    logic [7:0] m;
    m = (lc == 0) ? 8'h3F : (lc == 1) ? 8'h7F : 8'hFF;
    return {7'd0, md & d[8], d[7:0] & m};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rdr(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = (a == 3'd5);
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(input logic [10:0] f, input int cnt);
    for (int i = 0; i < cnt; i++) begin
      rxd = f[i];
      repeat (BITP) @(negedge clk);
    end
    rxd = 1'b1;
    repeat (BITP) @(negedge clk);
  endtask

  task automatic capture(input int cnt, output logic [10:0] got);
    int w;
    got = '1;
    w = 0;
    @(negedge clk);
    while (txd !== 1'b0 && w < 4000) begin
      @(negedge clk);
      w++;
    end
    repeat (BITP/2) @(negedge clk);
    for (int i = 0; i < cnt; i++) begin
      got[i] = txd;
      repeat (BITP) @(negedge clk);
    end
  endtask

  initial begin
    logic [15:0] v, s;
    logic [10:0] f, got, msk;
    int cnt, lows;
    void'($urandom(32'h5EED));

    idle(3);
    rst_n = 1'b1;
    idle(2);
    rdr(3'd6, s);
    chk("R1 status after reset", s, 16'h0006);
    chk("R1 txd idle", {15'd0, txd}, 16'd1);
    chk("R1 irq low", {15'd0, irq}, 16'd0);
    wr(3'd3, CDV);

    // random frames: out on txd, then back through local loopback
    for (int k = 0; k < 10; k++) begin
      int lc, pm;
      bit md;
      logic [8:0] d;
      lc = $urandom % 3;
      pm = $urandom % 5;
      md = $urandom % 2;
      d  = 9'($urandom % 512);
      wr(3'd1, mval(lc, pm, md, 0));
      wr(3'd4, {7'd0, d});
      f = bframe(d, lc, pm, md, 1'b1, cnt);
      capture(cnt, got);
      msk = 11'((1 << cnt) - 1);
      chk("R2 R3 R4 tx frame", {5'd0, got & msk}, {5'd0, f & msk});
      idle(BITP);
      wr(3'd1, mval(lc, pm, md, 2));
      wr(3'd4, {7'd0, d});
      idle(BITP * (cnt + 3));
      rdr(3'd5, v);
      chk("R5 R4 loopback data", v, rx_expect(d, lc, md));
      rdr(3'd6, s);
      chk("R5 R6 ready cleared, no errors", s & 16'h0071, 16'h0000);
    end

    // parity error, 8 bits even
    wr(3'd1, mval(2, 0, 0, 0));
    f = bframe(9'h035, 2, 0, 0, 1'b1, cnt);
    f[9] = ~f[9];
    drive(f, cnt);
    rdr(3'd6, s);
    chk("R6 parity error flagged", s & 16'h0071, 16'h0041);
    wr(3'd0, 16'h0001);
    rdr(3'd6, s);
    chk("R14 clear keeps ready", s & 16'h0071, 16'h0001);
    rdr(3'd5, v);
    chk("R5 data with parity error", v, 16'h0035);

    // framing error, 8 bits no parity
    wr(3'd1, mval(2, 4, 0, 0));
    f = bframe(9'h05A, 2, 4, 0, 1'b0, cnt);
    drive(f, cnt);
    idle(BITP);
    rdr(3'd6, s);
    chk("R7 framing error flagged", s & 16'h0079, 16'h0021);
    wr(3'd0, 16'h0001);
    rdr(3'd5, v);

    // overrun
    f = bframe(9'h011, 2, 4, 0, 1'b1, cnt);
    drive(f, cnt);
    f = bframe(9'h022, 2, 4, 0, 1'b1, cnt);
    drive(f, cnt);
    rdr(3'd6, s);
    chk("R8 overrun flagged", s & 16'h0011, 16'h0011);
    rdr(3'd5, v);
    chk("R8 newest character kept", v, 16'h0022);
    wr(3'd0, 16'h0001);

    // multidrop receive
    wr(3'd1, mval(2, 0, 1, 0));
    f = bframe(9'h1A5, 2, 0, 1, 1'b1, cnt);
    drive(f, cnt);
    rdr(3'd5, v);
    chk("R4 address marker received", v, 16'h01A5);
    f = bframe(9'h0A5, 2, 0, 1, 1'b1, cnt);
    drive(f, cnt);
    rdr(3'd5, v);
    chk("R4 data marker received", v, 16'h00A5);

    // break detection, reported once per low period
    wr(3'd1, mval(2, 4, 0, 0));
    rxd = 1'b0;
    idle(BITP * 14);
    rdr(3'd6, s);
    chk("R10 break seen, no character", s & 16'h0009, 16'h0008);
    wr(3'd0, 16'h0001);
    idle(BITP * 14);
    rdr(3'd6, s);
    chk("R10 no repeat while low", s & 16'h0009, 16'h0000);
    rxd = 1'b1;
    idle(BITP * 2);
    rxd = 1'b0;
    idle(BITP * 14);
    rdr(3'd6, s);
    chk("R10 new break after high", s & 16'h0008, 16'h0008);
    rxd = 1'b1;
    idle(BITP * 2);
    wr(3'd0, 16'h0001);

    // break generation
    wr(3'd0, 16'h0002);
    idle(2);
    chk("R9 break drives low", {15'd0, txd}, 16'd0);
    idle(100);
    chk("R9 break held", {15'd0, txd}, 16'd0);
    wr(3'd0, 16'h0004);
    idle(2);
    chk("R9 break released", {15'd0, txd}, 16'd1);

    // echo mode
    wr(3'd1, mval(2, 4, 0, 1));
    @(negedge clk); rxd = 1'b0;
    #1 chk("R11 echo follows low", {15'd0, txd}, 16'd0);
    @(negedge clk); rxd = 1'b1;
    #1 chk("R11 echo follows high", {15'd0, txd}, 16'd1);
    idle(BITP);
    f = bframe(9'h03C, 2, 4, 0, 1'b1, cnt);
    drive(f, cnt);
    rdr(3'd5, v);
    chk("R11 echo still receives", v, 16'h003C);

    // remote loopback
    wr(3'd1, mval(2, 4, 0, 3));
    @(negedge clk); rxd = 1'b0;
    #1 chk("R11 remote follows low", {15'd0, txd}, 16'd0);
    @(negedge clk); rxd = 1'b1;
    idle(BITP);
    f = bframe(9'h055, 2, 4, 0, 1'b1, cnt);
    drive(f, cnt);
    rdr(3'd6, s);
    chk("R11 remote receives nothing", s & 16'h0001, 16'h0000);

    // local loopback keeps pin high
    wr(3'd1, mval(2, 4, 0, 2));
    wr(3'd4, 16'h0066);
    idle(BITP * 3);
    chk("R11 local pin idle", {15'd0, txd}, 16'd1);
    idle(BITP * 10);
    rdr(3'd5, v);
    chk("R11 local receives", v, 16'h0066);

    // interrupt mask
    wr(3'd1, mval(2, 4, 0, 0));
    wr(3'd2, 16'h0000);
    idle(1);
    chk("R12 masked off", {15'd0, irq}, 16'd0);
    wr(3'd2, 16'h0002);
    idle(1);
    chk("R12 holding free raises irq", {15'd0, irq}, 16'd1);
    wr(3'd2, 16'h0001);
    idle(1);
    chk("R12 nothing ready", {15'd0, irq}, 16'd0);
    f = bframe(9'h042, 2, 4, 0, 1'b1, cnt);
    drive(f, cnt);
    chk("R12 ready raises irq", {15'd0, irq}, 16'd1);
    rdr(3'd5, v);
    idle(1);
    chk("R12 read drops irq", {15'd0, irq}, 16'd0);
    wr(3'd2, 16'h0000);

    // zero divisor stops transmission
    wr(3'd3, 16'h0000);
    wr(3'd4, 16'h000F);
    lows = 0;
    repeat (600) begin
      @(negedge clk);
      if (txd == 1'b0) lows++;
    end
    chk("R13 no output with zero divisor", 16'(lows), 16'd0);
    rdr(3'd6, s);
    chk("R13 character held", s & 16'h0006, 16'h0000);
    wr(3'd3, CDV);
    f = bframe(9'h00F, 2, 4, 0, 1'b1, cnt);
    capture(cnt, got);
    msk = 11'((1 << cnt) - 1);
    chk("R13 resumes after divisor", {5'd0, got & msk}, {5'd0, f & msk});

    idle(BITP * 2);
    summary();
  end
endmodule